// File: doc/BRIEF.md
# Operand Forwarding and Branch Hazard Stall Unit

This block resolves data hazards in a five-stage in-order pipeline (fetch, decode, read, execute, writeback) in which branches are decided in decode. Two source operands are about to enter execute. For each one, the block compares its register number with the destination registers of the instruction now in execute and the instruction now in writeback. It then selects the operand value from the register file read, from the writeback result, or from the execute result. It drives both the chosen value and a 2-bit select code.

A branch evaluated in decode may need a register whose value is still being computed in execute. That value cannot be forwarded in time. In this case the block raises a freeze for the fetch and decode stages. It also raises a bubble request, which loads a no-op into the pipeline register that feeds the read stage. A value being written back is visible to a decode-stage register read in the same cycle, so a dependency on writeback alone never stalls. The whole block is combinational.

Top module: `hz_unit`

## Requirements
- R1: An operand's select is 2'b10 and its value equals the execute result when the execute stage's write enable is high and its destination equals that operand's nonzero source register.
- R2: When R1 does not apply, an operand's select is 2'b01 and its value equals the writeback result when the writeback write enable is high and its destination equals that operand's nonzero source register.
- R3: When neither R1 nor R2 applies, an operand's select is 2'b00 and its value equals the register-file value supplied for it.
- R4: When execute and writeback both match the same source, execute wins (select 2'b10).
- R5: Register number 0 is never forwarded and never causes a freeze, even if a write-enabled stage names register 0 as its destination.
- R6: Operand A and operand B are resolved independently, each with its own select and value.
- R7: The freeze output is high when a valid decode branch uses a source register (per-source use flag) that equals the nonzero destination of a write-enabled instruction in execute.
- R8: A decode branch whose used sources match only the writeback destination does not freeze.
- R9: The bubble output is high in exactly the cycles in which the freeze output is high.
- R10: No freeze occurs when the branch-valid input is low, or when the matching source has its use flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_src_a_i | input | 5 | Source register of operand A entering execute |
| rd_src_b_i | input | 5 | Source register of operand B entering execute |
| rf_a_i | input | 32 | Register-file value read for operand A |
| rf_b_i | input | 32 | Register-file value read for operand B |
| ex_dst_i | input | 5 | Destination register of the instruction in execute |
| ex_we_i | input | 1 | Write enable of the instruction in execute |
| ex_res_i | input | 32 | Result produced in execute |
| wb_dst_i | input | 5 | Destination register of the instruction in writeback |
| wb_we_i | input | 1 | Write enable of the instruction in writeback |
| wb_res_i | input | 32 | Result being written back |
| br_valid_i | input | 1 | A branch is being evaluated in decode |
| br_use_a_i | input | 1 | The decode branch reads its first source |
| br_use_b_i | input | 1 | The decode branch reads its second source |
| br_src_a_i | input | 5 | First source register of the decode branch |
| br_src_b_i | input | 5 | Second source register of the decode branch |
| op_a_o | output | 32 | Resolved operand A value |
| op_b_o | output | 32 | Resolved operand B value |
| sel_a_o | output | 2 | Operand A source: 00 register file, 01 writeback, 10 execute |
| sel_b_o | output | 2 | Operand B source, same encoding |
| freeze_o | output | 1 | Hold fetch and decode |
| bubble_o | output | 1 | Load a no-op into the read-stage pipeline register |

## Verification
Assertions check on every evaluation that each select code agrees with the value it delivers, that register 0 never yields a forward or a freeze, and that a writeback selection never occurs while execute also matches. They also check that bubble tracks freeze and that a freeze only occurs with a valid branch. The priority between two matching stages, the independence of the two operands, and the cases that must not freeze (writeback-only match, unused source, no branch) are shown only by the bench's scenarios. Each scenario compares the outputs with values computed from the requirements.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF = 2'b00,
        FWD_WB = 2'b01,
        FWD_EX = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
    import hz_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic [AW-1:0] src_i,
    input  logic [DW-1:0] rf_val_i,
    input  logic [AW-1:0] ex_dst_i,
    input  logic          ex_we_i,
    input  logic [DW-1:0] ex_val_i,
    input  logic [AW-1:0] wb_dst_i,
    input  logic          wb_we_i,
    input  logic [DW-1:0] wb_val_i,
    output fwd_sel_e      sel_o,
    output logic [DW-1:0] val_o
);
    typedef struct packed {
        fwd_sel_e      sel;
        logic [DW-1:0] val;
    } opnd_t;

    opnd_t opnd_d;
    logic  src_live, ex_hit, wb_hit;

    always_comb begin
        src_live   = (src_i != '0);
        ex_hit     = src_live && ex_we_i && (ex_dst_i == src_i);
        wb_hit     = src_live && wb_we_i && (wb_dst_i == src_i);
        opnd_d.sel = FWD_RF;
        opnd_d.val = rf_val_i;
        if (ex_hit) begin
            opnd_d.sel = FWD_EX;   // newest producer first
            opnd_d.val = ex_val_i;
        end else if (wb_hit) begin
            opnd_d.sel = FWD_WB;
            opnd_d.val = wb_val_i;
        end
    end

    assign sel_o = opnd_d.sel;
    assign val_o = opnd_d.val;

    always_comb begin
        if (sel_o == FWD_EX)
            assert_ex_value_R1: assert (val_o == ex_val_i);
        if (sel_o == FWD_WB)
            assert_wb_value_R2: assert (val_o == wb_val_i);
        if (sel_o == FWD_WB)
            assert_ex_priority_R4: assert (!(ex_we_i && ex_dst_i == src_i));
        if (sel_o != FWD_RF)
            assert_no_zero_fwd_R5: assert (src_i != '0);
    end
endmodule

// File: rtl/hz_branch_stall.sv
module hz_branch_stall #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic                     br_valid_i,
    input  logic [NSRC-1:0]          use_i,
    input  logic [NSRC-1:0][AW-1:0]  src_i,
    input  logic [AW-1:0]            ex_dst_i,
    input  logic                     ex_we_i,
    output logic                     freeze_o,
    output logic                     bubble_o
);
    typedef struct packed {
        logic freeze;
        logic bubble;
    } stall_t;

    logic [NSRC-1:0] hit;
    stall_t          stall_d;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = use_i[g] && (src_i[g] != '0) && (src_i[g] == ex_dst_i);
    end

    always_comb begin
        stall_d.freeze = br_valid_i && ex_we_i && (|hit);
        stall_d.bubble = stall_d.freeze;
    end

    assign freeze_o = stall_d.freeze;
    assign bubble_o = stall_d.bubble;

    always_comb begin
        if (freeze_o)
            assert_freeze_needs_branch_R10: assert (br_valid_i && ex_we_i);
        if (freeze_o)
            assert_no_zero_stall_R5: assert (ex_dst_i != '0);
    end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic [AW-1:0] rd_src_a_i,
    input  logic [AW-1:0] rd_src_b_i,
    input  logic [DW-1:0] rf_a_i,
    input  logic [DW-1:0] rf_b_i,
    input  logic [AW-1:0] ex_dst_i,
    input  logic          ex_we_i,
    input  logic [DW-1:0] ex_res_i,
    input  logic [AW-1:0] wb_dst_i,
    input  logic          wb_we_i,
    input  logic [DW-1:0] wb_res_i,
    input  logic          br_valid_i,
    input  logic          br_use_a_i,
    input  logic          br_use_b_i,
    input  logic [AW-1:0] br_src_a_i,
    input  logic [AW-1:0] br_src_b_i,
    output logic [DW-1:0] op_a_o,
    output logic [DW-1:0] op_b_o,
    output logic [1:0]    sel_a_o,
    output logic [1:0]    sel_b_o,
    output logic          freeze_o,
    output logic          bubble_o
);
    localparam int NOPND = 2;

    logic [NOPND-1:0][AW-1:0] src_d;
    logic [NOPND-1:0][DW-1:0] rf_d;
    logic [NOPND-1:0][DW-1:0] val_d;
    fwd_sel_e                 sel_d [NOPND];

    assign src_d = {rd_src_b_i, rd_src_a_i};
    assign rf_d  = {rf_b_i, rf_a_i};

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        hz_operand_fwd #(.AW(AW), .DW(DW)) u_fwd (
            .src_i   (src_d[g]),
            .rf_val_i(rf_d[g]),
            .ex_dst_i(ex_dst_i),
            .ex_we_i (ex_we_i),
            .ex_val_i(ex_res_i),
            .wb_dst_i(wb_dst_i),
            .wb_we_i (wb_we_i),
            .wb_val_i(wb_res_i),
            .sel_o   (sel_d[g]),
            .val_o   (val_d[g])
        );
    end

    assign op_a_o  = val_d[0];
    assign op_b_o  = val_d[1];
    assign sel_a_o = sel_d[0];
    assign sel_b_o = sel_d[1];

    hz_branch_stall #(.AW(AW), .NSRC(NOPND)) u_stall (
        .br_valid_i(br_valid_i),
        .use_i     ({br_use_b_i, br_use_a_i}),
        .src_i     ({br_src_b_i, br_src_a_i}),
        .ex_dst_i  (ex_dst_i),
        .ex_we_i   (ex_we_i),
        .freeze_o  (freeze_o),
        .bubble_o  (bubble_o)
    );

    always_comb begin
        assert_bubble_follows_freeze_R9: assert (bubble_o == freeze_o);
        if (freeze_o)
            assert_freeze_hits_use_R7: assert (br_use_a_i || br_use_b_i);
    end
endmodule

// File: tb/sim_hz_unit.sv
module sim_hz_unit;
    localparam int AW = 5;
    localparam int DW = 32;
    localparam logic [DW-1:0] EXV = 32'hE0E0_0001;
    localparam logic [DW-1:0] WBV = 32'hB0B0_0002;
    localparam logic [DW-1:0] RFA = 32'hA1A1_0003;
    localparam logic [DW-1:0] RFB = 32'hB2B2_0004;

    typedef struct packed {
        logic [4:0] sa, sb, exd, wbd;
        logic       exwe, wbwe, bv, ua, ub;
        logic [4:0] bsa, bsb;
        logic [1:0] esa, esb;
        logic       efz;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{5'd3, 5'd4, 5'd3, 5'd9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 2'd2, 2'd0, 1'b0}, // R1 R3
        '{5'd3, 5'd4, 5'd9, 5'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 2'd0, 2'd1, 1'b0}, // R2 R3
        '{5'd5, 5'd5, 5'd5, 5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 2'd2, 2'd2, 1'b0}, // R4
        '{5'd5, 5'd6, 5'd5, 5'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 2'd1, 2'd0, 1'b0}, // R1 needs we
        '{5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 2'd0, 2'd0, 1'b0}, // R5
        '{5'd7, 5'd8, 5'd8, 5'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 2'd1, 2'd2, 1'b0}, // R6
        '{5'd1, 5'd2, 5'd3, 5'd9, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd3, 5'd9, 2'd0, 2'd0, 1'b1}, // R7 via A
        '{5'd1, 5'd2, 5'd3, 5'd9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 5'd4, 5'd3, 2'd0, 2'd0, 1'b1}, // R7 via B
        '{5'd1, 5'd2, 5'd9, 5'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'd3, 5'd3, 2'd0, 2'd0, 1'b0}, // R8
        '{5'd1, 5'd2, 5'd3, 5'd9, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd3, 5'd0, 2'd0, 2'd0, 1'b0}, // R10 no branch
        '{5'd1, 5'd2, 5'd3, 5'd9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5'd3, 5'd3, 2'd0, 2'd0, 1'b0}, // R10 unused
        '{5'd1, 5'd2, 5'd0, 5'd9, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 2'd0, 2'd0, 1'b0}, // R5 stall
        '{5'd1, 5'd2, 5'd3, 5'd9, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd3, 5'd0, 2'd0, 2'd0, 1'b0}  // R7 needs we
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [AW-1:0] rd_src_a, rd_src_b, ex_dst, wb_dst, br_src_a, br_src_b;
    logic [DW-1:0] rf_a, rf_b, ex_res, wb_res, op_a, op_b;
    logic          ex_we, wb_we, br_valid, br_use_a, br_use_b, freeze, bubble;
    logic [1:0]    sel_a, sel_b;

    hz_unit #(.AW(AW), .DW(DW)) u0 (
        .rd_src_a_i(rd_src_a), .rd_src_b_i(rd_src_b),
        .rf_a_i(rf_a), .rf_b_i(rf_b),
        .ex_dst_i(ex_dst), .ex_we_i(ex_we), .ex_res_i(ex_res),
        .wb_dst_i(wb_dst), .wb_we_i(wb_we), .wb_res_i(wb_res),
        .br_valid_i(br_valid), .br_use_a_i(br_use_a), .br_use_b_i(br_use_b),
        .br_src_a_i(br_src_a), .br_src_b_i(br_src_b),
        .op_a_o(op_a), .op_b_o(op_b), .sel_a_o(sel_a), .sel_b_o(sel_b),
        .freeze_o(freeze), .bubble_o(bubble)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf);
        return (s == 2'd2) ? EXV : (s == 2'd1) ? WBV : rf;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        rd_src_a = v.sa;  rd_src_b = v.sb;
        ex_dst = v.exd;   wb_dst = v.wbd;
        ex_we = v.exwe;   wb_we = v.wbwe;
        br_valid = v.bv;  br_use_a = v.ua; br_use_b = v.ub;
        br_src_a = v.bsa; br_src_b = v.bsb;
        #1;
    endtask

    task automatic idle();
        rd_src_a = '0; rd_src_b = '0; ex_dst = '0; wb_dst = '0;
        ex_we = 1'b0; wb_we = 1'b0; br_valid = 1'b0;
        br_use_a = 1'b0; br_use_b = 1'b0; br_src_a = '0; br_src_b = '0;
    endtask

    initial begin
        rf_a = RFA; rf_b = RFB; ex_res = EXV; wb_res = WBV;
        idle();
        repeat (2) @(negedge clk);
        #1;
        chk("R3", "idle sel_a", {30'd0, sel_a}, 32'd0);
        chk("R3", "idle op_a", op_a, RFA);
        chk("R9", "idle freeze", {31'd0, freeze}, 32'd0);
        chk("R9", "idle bubble", {31'd0, bubble}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            chk("R1/R2/R3/R4/R5/R6", $sformatf("v%0d sel_a", i), {30'd0, sel_a}, {30'd0, VEC[i].esa});
            chk("R6", $sformatf("v%0d sel_b", i), {30'd0, sel_b}, {30'd0, VEC[i].esb});
            chk("R1/R2/R3", $sformatf("v%0d op_a", i), op_a, pick(VEC[i].esa, RFA));
            chk("R6", $sformatf("v%0d op_b", i), op_b, pick(VEC[i].esb, RFB));
            chk("R7/R8/R10", $sformatf("v%0d freeze", i), {31'd0, freeze}, {31'd0, VEC[i].efz});
            chk("R9", $sformatf("v%0d bubble", i), {31'd0, bubble}, {31'd0, VEC[i].efz});
        end

        // R5: write-enabled destination 0 with live wb data, source 0 reads register file
        apply('{5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 5'd0, 5'd0, 2'd0, 2'd0, 1'b0});
        chk("R5", "zero op_a", op_a, RFA);
        chk("R5", "zero op_b", op_b, RFB);
        chk("R5", "zero freeze", {31'd0, freeze}, 32'd0);

        // R1: changing the execute result is visible on a forwarded operand at once
        apply('{5'd12, 5'd13, 5'd12, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 2'd2, 2'd0, 1'b0});
        ex_res = 32'h1234_5678;
        #1;
        chk("R1", "new ex value", op_a, 32'h1234_5678);
        chk("R3", "b unaffected", op_b, RFB);
        ex_res = EXV;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (10000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule